// File: doc/BRIEF.md
# Bit-Addressable Data RAM Manipulation Unit

This block holds a 128-byte internal data RAM and performs single-bit operations on a sixteen-byte window that begins at byte 20H. A request carries an 8-bit bit address and a 3-bit operation code. The low three bits of the address pick a bit position. The next four bits pick a byte offset, which is added to the base 20H. The top bit must be zero. A request with the top bit set is refused and a range-error pulse is raised.

Each accepted request runs in two phases. In the read phase the addressed byte is copied into a temporary register. In the finish phase the selected bit is changed and the byte is written back to the same location. The same finish phase updates the result bit or the carry flag for the operations that do not modify RAM.

A separate byte port reads and writes any of the 128 RAM locations directly. Byte writes are held off while a bit operation is in progress.

Top module: `bitram_unit`

## Requirements
- R1: A bit address `a` selects bit position `a[2:0]` (weights 1, 2, 4) of RAM byte `20H + a[6:3]`, so bit addresses 00H..7FH cover bytes 20H..2FH.
- R2: Operation code 1 (clear) writes 0 into the selected bit and leaves the other seven bits of that byte unchanged.
- R3: Operation code 2 (set) writes 1 into the selected bit and leaves the other bits unchanged.
- R4: Operation code 3 (complement) inverts the selected bit and leaves the other bits unchanged.
- R5: Operation code 0 (test) drives the selected bit on `result_bit`, which holds it until the next completed operation, and leaves RAM unchanged.
- R6: Operation code 4 (bit to carry) loads the selected bit into `carry` and leaves RAM unchanged. `carry` changes only in the cycle where `done` is high.
- R7: Operation code 5 (carry to bit) writes the current `carry` value into the selected bit through the read-modify-write path.
- R8: A request is accepted at the clock edge where `req_valid` is high and `busy` is low. `busy` is then high for exactly two cycles. `done` is high for exactly the one cycle after `busy` falls.
- R9: Requests presented while `busy` is high are ignored.
- R10: A request whose bit address has bit 7 set raises `range_err` for one cycle. It does not raise `busy` or `done`, and it leaves RAM unchanged.
- R11: The byte port writes `bp_wdata` to `bp_addr` (0..127) when `bp_we` is high and `busy` is low. `bp_rdata` shows the byte at the `bp_addr` of the previous cycle. Byte writes while `busy` is high are dropped.
- R12: After reset, `busy`, `done`, `range_err`, `result_bit` and `carry` are 0.
- R13: Operation codes 6 and 7 are not accepted: `busy`, `done` and `range_err` stay low and RAM is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bit operation request |
| req_op | input | 3 | Operation code (0 test, 1 clear, 2 set, 3 complement, 4 bit to carry, 5 carry to bit) |
| req_baddr | input | 8 | Bit address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result_bit | output | 1 | Selected bit from the last completed operation |
| carry | output | 1 | Carry flag |
| range_err | output | 1 | One-cycle pulse for a bit address with bit 7 set |
| bp_addr | input | 7 | Byte port address |
| bp_we | input | 1 | Byte port write enable |
| bp_wdata | input | 8 | Byte port write data |
| bp_rdata | output | 8 | Byte port read data, one cycle after the address |

## Verification
The hardest case to reach is a collision inside the two busy cycles. A second bit request and a byte write arrive together while the first operation sits between its read and its write-back. Neither may disturb the byte being modified or any other byte. The bench issues a set operation and, one cycle later, drives a clear request for a neighbouring byte together with a byte write to that same neighbour. It then reads both bytes back and counts the `done` pulses. A carry round trip covers a second case: a bit is moved into `carry` and then written to a different bit position. This shows that a value computed in one operation reaches RAM through a later one.

// File: rtl/bitram_pkg.sv
package bitram_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = $clog2(BYTE_W);
  localparam int OFS_W    = 4;
  localparam int BADDR_W  = OFS_W + IDX_W + 1;
  localparam int RAM_AW   = 7;
  localparam int WIN_BASE = 32;
  localparam int WIN_SIZE = 1 << OFS_W;

  typedef enum logic [2:0] {
    OP_TEST  = 3'd0,
    OP_CLR   = 3'd1,
    OP_SET   = 3'd2,
    OP_CPL   = 3'd3,
    OP_TOC   = 3'd4,
    OP_FROMC = 3'd5
  } bitop_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_READ = 2'd1,
    PH_FIN  = 2'd2
  } phase_e;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic logic op_writes(input logic [2:0] code);
    return (code == OP_CLR) || (code == OP_SET) ||
           (code == OP_CPL) || (code == OP_FROMC);
  endfunction
endpackage

// File: rtl/bitram_decode.sv
module bitram_decode
  import bitram_pkg::*;
#(
  parameter int P_OFS_W = OFS_W,
  parameter int P_IDX_W = IDX_W,
  parameter int P_AW    = RAM_AW,
  parameter int P_BASE  = WIN_BASE
) (
  input  logic [P_OFS_W+P_IDX_W:0] baddr,
  output logic [P_AW-1:0]          byte_addr,
  output logic [P_IDX_W-1:0]       bit_idx,
  output logic                     out_of_range
);
  localparam int TOP = P_OFS_W + P_IDX_W;
  localparam int SPAN = 1 << P_OFS_W;

  logic [P_OFS_W-1:0] ofs;

  always_comb begin
    ofs          = baddr[TOP-1:P_IDX_W];
    bit_idx      = baddr[P_IDX_W-1:0];
    out_of_range = baddr[TOP];
    byte_addr    = P_AW'(P_BASE) + P_AW'(ofs);
  end

  always_comb begin
    if (!$isunknown(baddr)) begin
      a_r1_decode_window: assert (int'(byte_addr) >= P_BASE &&
                                  int'(byte_addr) < P_BASE + SPAN)
        else $error("decoded byte outside bit window");
    end
  end
endmodule

// File: rtl/bitram_alu.sv
module bitram_alu
  import bitram_pkg::*;
#(
  parameter int P_W     = BYTE_W,
  parameter int P_IDX_W = IDX_W
) (
  input  logic [P_W-1:0]     din,
  input  logic [P_IDX_W-1:0] idx,
  input  logic [2:0]         op,
  input  logic               cin,
  output logic [P_W-1:0]     dout,
  output logic               bit_out
);
  logic new_bit;

  always_comb begin
    bit_out = din[idx];
    unique case (op)
      OP_CLR:   new_bit = 1'b0;
      OP_SET:   new_bit = 1'b1;
      OP_CPL:   new_bit = ~bit_out;
      OP_FROMC: new_bit = cin;
      default:  new_bit = bit_out;
    endcase
  end

  for (genvar i = 0; i < P_W; i++) begin : g_lane
    assign dout[i] = (idx == P_IDX_W'(i)) ? new_bit : din[i];
  end

  always_comb begin
    if (!$isunknown({din, idx, op, cin})) begin
      a_r2_single_lane: assert ($countones(dout ^ din) <= 1 &&
                                ((dout ^ din) & ~(P_W'(1) << idx)) == '0)
        else $error("bit operation touched an unselected lane");
    end
  end
endmodule

// File: rtl/bitram_store.sv
module bitram_store #(
  parameter int P_AW = 7,
  parameter int P_DW = 8
) (
  input  logic            clk,
  input  logic            rst_q_n,
  input  logic            we,
  input  logic [P_AW-1:0] waddr,
  input  logic [P_DW-1:0] wdata,
  input  logic [P_AW-1:0] op_addr,
  output logic [P_DW-1:0] op_rdata,
  input  logic [P_AW-1:0] port_addr,
  output logic [P_DW-1:0] port_rdata
);
  localparam int DEPTH = 1 << P_AW;

  logic [P_DW-1:0] mem [DEPTH];
  logic [P_DW-1:0] port_rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign op_rdata = mem[op_addr];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) port_rdata_q <= '0;
    else          port_rdata_q <= mem[port_addr];
  end

  assign port_rdata = port_rdata_q;
endmodule

// File: rtl/bitram_unit.sv
module bitram_unit
  import bitram_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [BADDR_W-1:0] req_baddr,
  output logic               busy,
  output logic               done,
  output logic               result_bit,
  output logic               carry,
  output logic               range_err,
  input  logic [RAM_AW-1:0]  bp_addr,
  input  logic               bp_we,
  input  logic [BYTE_W-1:0]  bp_wdata,
  output logic [BYTE_W-1:0]  bp_rdata
);
  // reset synchronizer: asynchronous assertion, synchronous release
  logic rs_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_q_n <= rs_meta;
    end
  end

  // request decode
  logic [RAM_AW-1:0] dec_addr;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_oor;

  bitram_decode #(
    .P_OFS_W(OFS_W), .P_IDX_W(IDX_W), .P_AW(RAM_AW), .P_BASE(WIN_BASE)
  ) u_dec (
    .baddr(req_baddr), .byte_addr(dec_addr), .bit_idx(dec_idx),
    .out_of_range(dec_oor)
  );

  // state
  phase_e            ph_q, ph_d;
  logic [RAM_AW-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [2:0]        op_q;
  logic [BYTE_W-1:0] tmp_q;
  logic              carry_q, result_q, done_q, oor_q;

  logic              idle, take, refuse, ld_tmp, fin;
  logic [BYTE_W-1:0] ram_rd, alu_out;
  logic              alu_bit;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [BYTE_W-1:0] ram_wdata;

  always_comb begin
    idle   = (ph_q == PH_IDLE);
    take   = idle && req_valid && op_legal(req_op) && !dec_oor;
    refuse = idle && req_valid && op_legal(req_op) && dec_oor;
    ld_tmp = (ph_q == PH_READ);
    fin    = (ph_q == PH_FIN);
  end

  // next-state process
  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (take) ph_d = PH_READ;
      PH_READ: ph_d = PH_FIN;
      PH_FIN:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ph_q     <= PH_IDLE;
      addr_q   <= '0;
      idx_q    <= '0;
      op_q     <= '0;
      tmp_q    <= '0;
      carry_q  <= 1'b0;
      result_q <= 1'b0;
      done_q   <= 1'b0;
      oor_q    <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= fin;
      oor_q  <= refuse;
      if (take) begin
        addr_q <= dec_addr;
        idx_q  <= dec_idx;
        op_q   <= req_op;
      end
      if (ld_tmp) tmp_q <= ram_rd;
      if (fin) result_q <= alu_bit;
      if (fin && op_q == OP_TOC) carry_q <= alu_bit;
    end
  end

  bitram_alu #(.P_W(BYTE_W), .P_IDX_W(IDX_W)) u_alu (
    .din(tmp_q), .idx(idx_q), .op(op_q), .cin(carry_q),
    .dout(alu_out), .bit_out(alu_bit)
  );

  // write port arbitration: bit write-back owns the port while busy
  always_comb begin
    if (fin) begin
      ram_we    = op_writes(op_q);
      ram_waddr = addr_q;
      ram_wdata = alu_out;
    end else begin
      ram_we    = bp_we && idle;
      ram_waddr = bp_addr;
      ram_wdata = bp_wdata;
    end
  end

  bitram_store #(.P_AW(RAM_AW), .P_DW(BYTE_W)) u_ram (
    .clk(clk), .rst_q_n(rst_q_n),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .op_addr(addr_q), .op_rdata(ram_rd),
    .port_addr(bp_addr), .port_rdata(bp_rdata)
  );

  assign busy       = !idle;
  assign done       = done_q;
  assign result_bit = result_q;
  assign carry      = carry_q;
  assign range_err  = oor_q;

  a_r8_busy_span: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(busy) |=> (busy && !done))
    else $error("busy shorter than two cycles");

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |-> (!busy && $past(busy)))
    else $error("done not right after busy");

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done)
    else $error("done wider than one cycle");

  a_r10_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    range_err |-> (!busy && !done))
    else $error("range error with activity");

  a_r6_carry_on_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(carry) |-> done)
    else $error("carry moved outside completion");

  a_r11_port_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ram_we && !fin) |-> !busy)
    else $error("byte write while busy");
endmodule

// File: tb/sim_bitram_unit.sv
module sim_bitram_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_op;
  logic [7:0] req_baddr;
  logic       busy, done, result_bit, carry, range_err;
  logic [6:0] bp_addr;
  logic       bp_we;
  logic [7:0] bp_wdata;
  logic [7:0] bp_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  bitram_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_baddr(req_baddr), .busy(busy), .done(done), .result_bit(result_bit),
    .carry(carry), .range_err(range_err), .bp_addr(bp_addr), .bp_we(bp_we),
    .bp_wdata(bp_wdata), .bp_rdata(bp_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bp_addr = a; bp_wdata = d; bp_we = 1'b1;
    @(negedge clk); bp_we = 1'b0;
  endtask

  task automatic bread(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); bp_addr = a;
    @(negedge clk); d = bp_rdata;
  endtask

  // issue one request and check the R8 timing on the way
  task automatic issue(input logic [2:0] op, input logic [7:0] ba);
    @(negedge clk); req_valid = 1'b1; req_op = op; req_baddr = ba;
    @(negedge clk); req_valid = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R8 busy cycle 1", busy, 1);
    @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R8 busy cycle 2", busy, 1);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b1, "R8 done pulse", {busy, done}, 1);
    @(negedge clk);
    chk(done === 1'b0, "R8 done single", done, 0);
  endtask

  task automatic t_reset;
    chk(busy === 0 && done === 0 && range_err === 0, "R12 reset flags",
        {busy, done, range_err}, 0);
    chk(result_bit === 0 && carry === 0, "R12 reset result/carry",
        {result_bit, carry}, 0);
  endtask

  task automatic t_byteport;
    logic [7:0] d;
    bwrite(7'h05, 8'h3C); bwrite(7'h7F, 8'hC3);
    bread(7'h05, d); chk(d === 8'h3C, "R11 byte rw low", d, 8'h3C);
    bread(7'h7F, d); chk(d === 8'hC3, "R11 byte rw top", d, 8'hC3);
  endtask

  task automatic t_set_decode;
    logic [7:0] d;
    for (int k = 0; k < 16; k++) bwrite(7'(32 + k), 8'h00);
    issue(3'd2, 8'h00); bread(7'h20, d);
    chk(d === 8'h01, "R3 set byte20 bit0", d, 8'h01);
    issue(3'd2, 8'h7F); bread(7'h2F, d);
    chk(d === 8'h80, "R1 set byte2F bit7", d, 8'h80);
    issue(3'd2, 8'h2D); bread(7'h25, d);
    chk(d === 8'h20, "R1 decode 2D -> byte25 bit5", d, 8'h20);
    bread(7'h24, d); chk(d === 8'h00, "R1 neighbour untouched", d, 8'h00);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    bwrite(7'h23, 8'hFF);
    issue(3'd1, 8'h1B); bread(7'h23, d);
    chk(d === 8'hF7, "R2 clear bit3", d, 8'hF7);
  endtask

  task automatic t_cpl;
    logic [7:0] d;
    bwrite(7'h26, 8'hA5);
    issue(3'd3, 8'h36); bread(7'h26, d);
    chk(d === 8'hE5, "R4 complement 0->1", d, 8'hE5);
    issue(3'd3, 8'h37); bread(7'h26, d);
    chk(d === 8'h65, "R4 complement 1->0", d, 8'h65);
  endtask

  task automatic t_test;
    logic [7:0] d;
    bwrite(7'h27, 8'h10);
    issue(3'd0, 8'h3C);
    chk(result_bit === 1'b1, "R5 test reads 1", result_bit, 1);
    issue(3'd0, 8'h3B);
    chk(result_bit === 1'b0, "R5 test reads 0", result_bit, 0);
    bread(7'h27, d); chk(d === 8'h10, "R5 ram unchanged", d, 8'h10);
  endtask

  task automatic t_carry;
    logic [7:0] d;
    bwrite(7'h28, 8'h02); bwrite(7'h29, 8'h00);
    issue(3'd4, 8'h41);
    chk(carry === 1'b1, "R6 carry loaded", carry, 1);
    bread(7'h28, d); chk(d === 8'h02, "R6 ram unchanged", d, 8'h02);
    issue(3'd5, 8'h4E); bread(7'h29, d);
    chk(d === 8'h40, "R7 carry into bit6", d, 8'h40);
    issue(3'd4, 8'h40);
    chk(carry === 1'b0, "R6 carry cleared", carry, 0);
    issue(3'd5, 8'h4E); bread(7'h29, d);
    chk(d === 8'h00, "R7 zero carry into bit6", d, 8'h00);
  endtask

  task automatic t_busy_collision;
    logic [7:0] d;
    int ndone = 0;
    bwrite(7'h2A, 8'h00); bwrite(7'h2B, 8'h55);
    @(negedge clk); req_valid = 1'b1; req_op = 3'd2; req_baddr = 8'h52;
    @(negedge clk); req_op = 3'd1; req_baddr = 8'h58;
    bp_addr = 7'h2B; bp_wdata = 8'hAA; bp_we = 1'b1;
    @(negedge clk); req_valid = 1'b0; bp_we = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); if (done) ndone++;
    end
    chk(ndone == 1, "R9 one completion", ndone, 1);
    bread(7'h2A, d); chk(d === 8'h04, "R9 first op done", d, 8'h04);
    bread(7'h2B, d); chk(d === 8'h55, "R11 busy write dropped", d, 8'h55);
  endtask

  task automatic t_oor;
    logic [7:0] d;
    bwrite(7'h20, 8'h00);
    @(negedge clk); req_valid = 1'b1; req_op = 3'd2; req_baddr = 8'h85;
    @(negedge clk); req_valid = 1'b0;
    chk(range_err === 1'b1 && busy === 1'b0, "R10 flag no busy",
        {range_err, busy}, 2);
    @(negedge clk);
    chk(range_err === 1'b0 && done === 1'b0, "R10 single pulse", range_err, 0);
    bread(7'h20, d); chk(d === 8'h00, "R10 ram unchanged", d, 8'h00);
  endtask

  task automatic t_badop;
    logic [7:0] d;
    bwrite(7'h2C, 8'h00);
    @(negedge clk); req_valid = 1'b1; req_op = 3'd6; req_baddr = 8'h60;
    @(negedge clk); req_op = 3'd7;
    chk(busy === 0 && range_err === 0, "R13 code 6 ignored", busy, 0);
    @(negedge clk); req_valid = 1'b0;
    chk(busy === 0 && range_err === 0, "R13 code 7 ignored", busy, 0);
    bread(7'h2C, d); chk(d === 8'h00, "R13 ram unchanged", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_baddr = '0;
    bp_addr = '0; bp_we = 1'b0; bp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_byteport;
    t_set_decode;
    t_clear;
    t_cpl;
    t_test;
    t_carry;
    t_busy_collision;
    t_oor;
    t_badop;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule